// File: doc/BRIEF.md
# Edge-Selectable Cascadable Up/Down Counter

This block is an auxiliary event counter. Its width is a parameter and defaults to 16 bits. It advances by one on edges taken from one of two sources, picked by a 3-bit edge code.

- **External count pin.** This input is asynchronous. It is synchronised and then filtered, so that only a level held for a minimum number of clocks produces an edge.
- **Companion toggle latch.** This is the toggle latch of a neighbouring core timer. A latch transition counts only when the neighbour's overflow or underflow caused it, and the neighbour flags that with a one-cycle strobe. Counting these transitions chains the two timers into one wider counter.

The count direction comes from a control bit. An external direction pin can optionally be exclusive-ORed with that bit. Software can load the count at any time. When the count wraps in either direction, the block raises a single-cycle interrupt request.

A typical use is to extend a core timer: pick one of the latch codes and set the run bit. A second typical use is to count external events: pick one of the pin codes.

Top module: `casc_edge_counter`

## Requirements
- R1: After reset, `count_q` is 0 and `irq` is low.
- R2: When `edge_sel[1:0]` is 00, no edge of either source changes the count, whatever `edge_sel[2]` is.
- R3: When `edge_sel[2]` is 0, the pin is the source. Code 001 counts rising pin edges only, 010 counts falling pin edges only, and 011 counts both.
- R4: When `edge_sel[2]` is 1, the latch is the source. Code 101 counts rising latch edges, 110 counts falling latch edges, and 111 counts both. A latch edge counts only if `tgl_hw` is high in the cycle in which the new latch level is first seen. A latch change with `tgl_hw` low never counts.
- R5: The pin passes through a two-flop synchroniser and then a filter that needs 3 consecutive equal samples. A level held for 4 clocks is always detected. A pulse of 2 clocks is ignored. A pin change made just after clock edge k appears on `count_q` right after edge k+6.
- R6: While `run` is low, no edge changes the count.
- R7: The direction is down when `dir_ctl ^ (ext_dir_en & dir_pin_sync)` is 1, and up otherwise. `dir_pin` passes through a two-flop synchroniser. When `ext_dir_en` is 0, `dir_pin` has no effect. A latch event applies the direction present in its own cycle.
- R8: Counting up from all-ones gives 0, and counting down from 0 gives all-ones. Each wrap drives `irq` high for exactly the one cycle in which the wrapped value first shows. No other count step raises `irq`.
- R9: When `wr_en` is high, `count_q` takes `wr_data` at the next edge. A count event in that same cycle is dropped and raises no `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| run | input | 1 | Counting enable |
| edge_sel | input | 3 | Edge code: bit 2 picks the source (0 = pin, 1 = latch); bits 1:0 are 01 rise, 10 fall, 11 both, 00 off |
| dir_ctl | input | 1 | Direction control bit (1 = down) |
| ext_dir_en | input | 1 | Lets the external direction pin take part |
| dir_pin | input | 1 | External direction pin, asynchronous |
| count_pin | input | 1 | External count pin, asynchronous |
| tgl_latch | input | 1 | Level of the companion timer's toggle latch |
| tgl_hw | input | 1 | High in the cycle in which a hardware overflow or underflow changed the latch |
| wr_en | input | 1 | Software load strobe |
| wr_data | input | CNT_W | Value to load |
| count_q | output | CNT_W | Counter value |
| irq | output | 1 | One-cycle wrap interrupt request |

## Verification
The hardest case to reach from the ports is a count event and a software load landing in the same clock cycle. The bench reaches it by driving the load strobe and a hardware-flagged latch toggle within the same cycle, so both are seen at one edge, and then checks that the loaded value wins.

A second hard case is telling a software latch change apart from a hardware one. The bench changes the latch level with the hardware flag both high and low, and checks that only the flagged change moves the count.

Pin filtering is reached with a pin pulse of two cycles, which must be rejected, and with levels held for exactly four cycles, which must each be counted.

// File: rtl/casc_cnt_pkg.sv
`timescale 1ns/1ps
package casc_cnt_pkg;

   // Bit 2 of the edge code picks the source.
   localparam int unsigned SRC_BIT = 2;

   typedef enum logic [1:0] {
      POL_OFF  = 2'b00,
      POL_RISE = 2'b01,
      POL_FALL = 2'b10,
      POL_BOTH = 2'b11
   } pol_e;

   // Picks the qualifying event from the edge code and the edge strobes of both sources.
   function automatic logic pick_event(input logic [2:0] code,
                                       input logic pin_r, input logic pin_f,
                                       input logic lat_r, input logic lat_f);
      logic r;
      logic f;
      r = code[SRC_BIT] ? lat_r : pin_r;
      f = code[SRC_BIT] ? lat_f : pin_f;
      case (pol_e'(code[1:0]))
         POL_RISE: return r;
         POL_FALL: return f;
         POL_BOTH: return r | f;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/casc_cnt_sync.sv
`timescale 1ns/1ps
module casc_cnt_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("casc_cnt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/casc_cnt_pin_filter.sv
`timescale 1ns/1ps
module casc_cnt_pin_filter #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned HOLD   = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise_o,
   output logic fall_o
);
   if (HOLD < 1 || HOLD > 4) begin : g_bad_hold
      $error("casc_cnt_pin_filter: HOLD must lie in 1..4 so that 4-cycle levels are seen");
   end

   logic smp;
   logic filt_q;
   logic rise_q;
   logic fall_q;

   casc_cnt_sync #(.STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin),
      .q     (smp)
   );

   if (HOLD == 1) begin : g_direct
      // Any change of the synchronised level is taken at once.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            filt_q <= 1'b0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
         end else begin
            filt_q <= smp;
            rise_q <= smp & ~filt_q;
            fall_q <= ~smp & filt_q;
         end
      end
   end else begin : g_window
      localparam int unsigned CW = $clog2(HOLD);
      localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
      logic [CW-1:0] run_q;

      // The filtered level moves only after HOLD samples that differ from it in a row.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            filt_q <= 1'b0;
            run_q  <= '0;
            rise_q <= 1'b0;
            fall_q <= 1'b0;
         end else begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
            if (smp != filt_q) begin
               if (run_q == LAST) begin
                  filt_q <= smp;
                  run_q  <= '0;
                  rise_q <= smp;
                  fall_q <= ~smp;
               end else begin
                  run_q <= run_q + 1'b1;
               end
            end else begin
               run_q <= '0;
            end
         end
      end
   end

   assign rise_o = rise_q;
   assign fall_o = fall_q;
endmodule

// File: rtl/casc_cnt_latch_edge.sv
`timescale 1ns/1ps
module casc_cnt_latch_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic latch,
   input  logic hw_flag,
   output logic rise_o,
   output logic fall_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= latch;
   end

   // A latch transition is an event only when the companion timer flags it as its own.
   assign rise_o = hw_flag &  latch & ~prev_q;
   assign fall_o = hw_flag & ~latch &  prev_q;
endmodule

// File: rtl/casc_cnt_core.sv
`timescale 1ns/1ps
module casc_cnt_core #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         evt,
   input  logic         down,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   output logic [W-1:0] count_o,
   output logic         irq_o
);
   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] cnt_q;
   logic         irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (wr_en) begin
            cnt_q <= wr_data;
         end else if (evt) begin
            if (down) begin
               cnt_q <= cnt_q - 1'b1;
               irq_q <= (cnt_q == '0);
            end else begin
               cnt_q <= cnt_q + 1'b1;
               irq_q <= (cnt_q == TOP);
            end
         end
      end
   end

   assign count_o = cnt_q;
   assign irq_o   = irq_q;
endmodule

// File: rtl/casc_edge_counter.sv
`timescale 1ns/1ps
module casc_edge_counter #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PIN_HOLD    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [2:0]       edge_sel,
   input  logic             dir_ctl,
   input  logic             ext_dir_en,
   input  logic             dir_pin,
   input  logic             count_pin,
   input  logic             tgl_latch,
   input  logic             tgl_hw,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] count_q,
   output logic             irq
);
   import casc_cnt_pkg::*;

   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
      $error("casc_edge_counter: CNT_W must lie in 2..64");
   end

   logic pin_rise;
   logic pin_fall;
   logic lat_rise;
   logic lat_fall;
   logic dir_s;
   logic cnt_evt;
   logic cnt_down;

   casc_cnt_pin_filter #(.STAGES(SYNC_STAGES), .HOLD(PIN_HOLD)) u_pin (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin    (count_pin),
      .rise_o (pin_rise),
      .fall_o (pin_fall)
   );

   casc_cnt_latch_edge u_lat (
      .clk     (clk),
      .rst_n   (rst_n),
      .latch   (tgl_latch),
      .hw_flag (tgl_hw),
      .rise_o  (lat_rise),
      .fall_o  (lat_fall)
   );

   casc_cnt_sync #(.STAGES(SYNC_STAGES)) u_dir_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dir_pin),
      .q     (dir_s)
   );

   assign cnt_evt  = run & pick_event(edge_sel, pin_rise, pin_fall, lat_rise, lat_fall);
   assign cnt_down = dir_ctl ^ (ext_dir_en & dir_s);

   casc_cnt_core #(.W(CNT_W)) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (cnt_evt),
      .down    (cnt_down),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .count_o (count_q),
      .irq_o   (irq)
   );
endmodule

// File: rtl/casc_cnt_chk.sv
`timescale 1ns/1ps
module casc_cnt_chk #(
   parameter int unsigned W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         run,
   input logic [2:0]   edge_sel,
   input logic         tgl_hw,
   input logic         wr_en,
   input logic [W-1:0] wr_data,
   input logic [W-1:0] count_q,
   input logic         irq
);
   assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (count_q == $past(wr_data)));

   assert_halt_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !wr_en) |=> $stable(count_q));

   assert_code_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[1:0] == 2'b00 && !wr_en) |=> $stable(count_q));

   assert_sw_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel[2] && !tgl_hw && !wr_en) |=> $stable(count_q));

   assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_irq_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (count_q == '0 || count_q == '1));

   assert_unit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (count_q == $past(count_q) ||
                  count_q == $past(count_q) + W'(1) ||
                  count_q == $past(count_q) - W'(1)));
endmodule

bind casc_edge_counter casc_cnt_chk #(.W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run),
   .edge_sel (edge_sel),
   .tgl_hw   (tgl_hw),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .count_q  (count_q),
   .irq      (irq)
);

// File: tb/casc_edge_counter_bench.sv
`timescale 1ns/1ps
module casc_edge_counter_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run = 1'b0;
   logic [2:0]   edge_sel = 3'b000;
   logic         dir_ctl = 1'b0;
   logic         ext_dir_en = 1'b0;
   logic         dir_pin = 1'b0;
   logic         count_pin = 1'b0;
   logic         tgl_latch = 1'b0;
   logic         tgl_hw = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] count_q;
   logic         irq;

   always #2.5 clk = ~clk;

   casc_edge_counter u_casc_edge_counter (
      .clk(clk), .rst_n(rst_n), .run(run), .edge_sel(edge_sel), .dir_ctl(dir_ctl),
      .ext_dir_en(ext_dir_en), .dir_pin(dir_pin), .count_pin(count_pin),
      .tgl_latch(tgl_latch), .tgl_hw(tgl_hw), .wr_en(wr_en), .wr_data(wr_data),
      .count_q(count_q), .irq(irq)
   );

   typedef struct {
      string        tag;
      logic [W-1:0] cnt;
      int           irqs;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   errors = 0;
   int   irq_seen = 0;
   bit   done = 1'b0;

   // Monitor: counts irq cycles and compares queued expectations at the falling edge.
   always @(negedge clk) begin
      if (rst_n && irq) irq_seen++;
      if (exp_q.size() > 0) begin
         exp_t it;
         it = exp_q.pop_front();
         checks++;
         if (count_q !== it.cnt || irq_seen != it.irqs) begin
            errors++;
            $display("FAIL %s: count=%h irqs=%0d, expected count=%h irqs=%0d",
                     it.tag, count_q, irq_seen, it.cnt, it.irqs);
         end
      end
   end

   // Driver: queues an expected item for the next falling edge.
   task automatic expect_now(input string tag, input logic [W-1:0] c, input int n);
      exp_t it;
      it.tag = tag; it.cnt = c; it.irqs = n;
      exp_q.push_back(it);
      @(negedge clk);
      #0.5;
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic pin_to(input logic v);
      step(); count_pin = v;
      repeat (9) step();
   endtask

   task automatic lat_toggle(input logic hw);
      step(); tgl_latch = ~tgl_latch; tgl_hw = hw;
      step(); tgl_hw = 1'b0;
   endtask

   task automatic load(input logic [W-1:0] v);
      step(); wr_en = 1'b1; wr_data = v;
      step(); wr_en = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) step();
      expect_now("R1 reset count", 16'h0000, 0);
      rst_n = 1'b1;
      run = 1'b1;
      step();

      // R3: pin source, each polarity
      edge_sel = 3'b001;
      pin_to(1); expect_now("R3 rise code 001", 16'd1, 0);
      pin_to(0); expect_now("R3 fall ignored by 001", 16'd1, 0);
      edge_sel = 3'b010;
      pin_to(1); expect_now("R3 rise ignored by 010", 16'd1, 0);
      pin_to(0); expect_now("R3 fall code 010", 16'd2, 0);
      edge_sel = 3'b011;
      pin_to(1); expect_now("R3 both codes rise", 16'd3, 0);
      pin_to(0); expect_now("R3 both codes fall", 16'd4, 0);

      // R2: low bits 00 disable with either source bit
      edge_sel = 3'b000;
      pin_to(1); pin_to(0);
      expect_now("R2 code 000 pin edges", 16'd4, 0);
      edge_sel = 3'b100;
      lat_toggle(1); lat_toggle(1);
      expect_now("R2 code 100 latch edges", 16'd4, 0);

      // R5: latency of the pin path, change after edge k shows after edge k+6
      edge_sel = 3'b011;
      step(); count_pin = 1'b1;
      repeat (5) @(posedge clk);
      #1 expect_now("R5 no count before sixth edge", 16'd4, 0);
      step(); expect_now("R5 count after sixth edge", 16'd5, 0);
      repeat (4) step();
      // R5: two-cycle low pulse rejected
      count_pin = 1'b0; step(); step(); count_pin = 1'b1;
      repeat (9) step();
      expect_now("R5 short pulse ignored", 16'd5, 0);
      // R5: four-cycle levels accepted
      count_pin = 1'b0; repeat (4) step(); count_pin = 1'b1;
      repeat (9) step();
      expect_now("R5 four-cycle levels", 16'd7, 0);

      // R4: latch source, only hardware toggles count
      edge_sel = 3'b101;
      lat_toggle(1); expect_now("R4 hw rise code 101", 16'd8, 0);
      lat_toggle(1); expect_now("R4 hw fall ignored by 101", 16'd8, 0);
      lat_toggle(0); expect_now("R4 sw rise ignored", 16'd8, 0);
      lat_toggle(0);
      edge_sel = 3'b110;
      lat_toggle(1); lat_toggle(1); expect_now("R4 code 110 fall only", 16'd9, 0);
      edge_sel = 3'b111;
      lat_toggle(1); lat_toggle(1); expect_now("R4 code 111 both", 16'd11, 0);
      lat_toggle(0); lat_toggle(0); expect_now("R4 sw toggles code 111", 16'd11, 0);
      edge_sel = 3'b011;
      pin_to(0); pin_to(1);
      expect_now("R4 pin ignored? no, R3 pin path still live", 16'd13, 0);
      edge_sel = 3'b111;

      // R6: run low blocks counting
      run = 1'b0;
      lat_toggle(1); lat_toggle(1); expect_now("R6 run low", 16'd13, 0);
      run = 1'b1;

      // R7: direction
      dir_ctl = 1'b1;
      lat_toggle(1); expect_now("R7 control bit down", 16'd12, 0);
      ext_dir_en = 1'b1; dir_pin = 1'b1; repeat (4) step();
      lat_toggle(1); expect_now("R7 pin xor control up", 16'd13, 0);
      dir_ctl = 1'b0;
      lat_toggle(1); expect_now("R7 pin alone down", 16'd12, 0);
      ext_dir_en = 1'b0;
      lat_toggle(1); expect_now("R7 pin ignored when disabled", 16'd13, 0);
      dir_pin = 1'b0;

      // R9 load, then R8 wraps
      load(16'hFFFF); expect_now("R9 load value", 16'hFFFF, 0);
      lat_toggle(1); expect_now("R8 wrap up with irq", 16'h0000, 1);
      dir_ctl = 1'b1;
      lat_toggle(1); expect_now("R8 wrap down with irq", 16'hFFFF, 2);
      lat_toggle(1); expect_now("R8 plain step no irq", 16'hFFFE, 2);
      dir_ctl = 1'b0;

      // R9: load and count event in the same cycle
      load(16'hFFFF);
      step(); wr_en = 1'b1; wr_data = 16'h1234; tgl_latch = ~tgl_latch; tgl_hw = 1'b1;
      step(); wr_en = 1'b0; tgl_hw = 1'b0;
      expect_now("R9 load beats event", 16'h1234, 2);

      repeat (3) step();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule